// File: doc/BRIEF.md
# Serial Clock and Edge Strobe Generator

This block sits between a serial-peripheral shift engine and the pins. It gives the shift logic one pair of strobes, one for rising serial-clock edges and one for falling edges, and each strobe lasts a single system-clock cycle. The strobes come from one of two sources, chosen by a mode input.

As bus master, the block builds the serial clock from the system clock in two cascaded stages. A prescaler with a programmable terminal count comes first. A fixed divide-by-two toggle stage follows it, so the duty cycle is always 50%. The clock runs only while the active-low chip-select is asserted. At all other times it rests at the idle level chosen by the polarity input. The prescaler restarts from zero on every assertion, so the first edge always comes a known number of cycles after chip-select falls.

As a slave, the block stops driving the clock. It passes the clock from the external master through a two-stage synchronizer, detects its transitions, and turns them into the same strobes.

A small state machine chooses the source. Its states are `ST_IDLE`, `ST_MASTER` and `ST_SLAVE`, with these transitions:
- `ST_IDLE` to `ST_MASTER` when chip-select is low and the mode is master.
- `ST_IDLE` to `ST_SLAVE` when chip-select is low and the mode is slave.
- `ST_MASTER` to `ST_IDLE`, and `ST_SLAVE` to `ST_IDLE`, when chip-select goes high.
- `ST_MASTER` to `ST_SLAVE`, and `ST_SLAVE` to `ST_MASTER`, directly when the mode input flips while chip-select stays low.

The prescaler, the toggle stage and the slave edge detector all follow the next state. Because of this, a chip-select change takes effect at the very edge that samples it.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rst_n` is low, `sclk_out`, `sclk_rise` and `sclk_fall` are all 0.
- R2: When `cs_n` is sampled high at a clock edge, then after that edge `sclk_out` equals `cpol`, and `sclk_rise` and `sclk_fall` are 0.
- R3: In master mode (`slave_mode`=0), number the edges starting with 1 at the first edge that samples `cs_n` low. `sclk_out` inverts at each edge whose number is a multiple of `div_ratio`+1. The serial period is therefore 2*(`div_ratio`+1) system cycles, with equal high and low times.
- R4: In master mode, the first strobe after chip-select assertion is `sclk_fall` when `cpol`=1 and `sclk_rise` when `cpol`=0.
- R5: In master mode, `sclk_rise` is 1 in exactly those cycles in which `sclk_out` has just changed from 0 to 1, and `sclk_fall` in exactly those in which it has just changed from 1 to 0.
- R6: Each strobe is high for one cycle at a time, and the two strobes are never high together.
- R7: `sclk_oe` is 1 when `slave_mode`=0 and 0 when `slave_mode`=1.
- R8: In slave mode with `cs_n` low, suppose `sclk_in` changes before a rising clock edge A. Then the matching strobe (`sclk_rise` for 0 to 1, `sclk_fall` for 1 to 0) is high for the one cycle after edge A+2. The input must stay stable for at least four cycles between changes.
- R9: In slave mode with `cs_n` high, changes on `sclk_in` produce no strobe. In slave mode, `sclk_out` stays at `cpol`.
- R10: Deasserting `cs_n` and then asserting it again restarts the edge numbering of R3 from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 selects slave (external clock), 0 selects master |
| cpol | input | 1 | Idle level of the serial clock |
| div_ratio | input | DIV_W | Prescaler terminal count; the first stage divides by `div_ratio`+1 |
| cs_n | input | 1 | Chip-select, active low |
| sclk_in | input | 1 | Serial clock from the external master (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| sclk_rise | output | 1 | One-cycle strobe on each rising serial-clock edge |
| sclk_fall | output | 1 | One-cycle strobe on each falling serial-clock edge |

## Verification
The assertions assume that `div_ratio`, `cpol` and `slave_mode` do not change while `cs_n` is low. In slave mode they also assume that `sclk_in` holds each level for at least four system cycles, which keeps edges resolvable after the synchronizer. The stimulus changes configuration only while chip-select is deasserted. It draws random divisors, polarities and transfer lengths from a seeded generator, and it spaces the slave clock transitions with random gaps of four or more cycles. Directed cases cover the smallest divisor, chip-select reassertion, and slave transitions while chip-select is high.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASTER = 2'd1,
        ST_SLAVE  = 2'd2
    } sclk_state_e;
endpackage

// File: rtl/sck_prescale.sv
module sck_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= ratio);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(ratio)) |-> (cnt_q <= ratio));
endmodule

// File: rtl/sck_half_stage.sv
module sck_half_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic idle_lvl,
    input  logic tick,
    output logic sclk,
    output logic rise,
    output logic fall
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk <= 1'b0;
            rise <= 1'b0;
            fall <= 1'b0;
        end else if (!run) begin
            sclk <= idle_lvl;
            rise <= 1'b0;
            fall <= 1'b0;
        end else if (tick) begin
            sclk <= ~sclk;
            rise <= ~sclk;
            fall <= sclk;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
        end
    end
endmodule

// File: rtl/sck_sync_edge.sv
module sck_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   synced;

    assign synced = chain_q[SYNC_STAGES-1];

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      chain_q[i] <= 1'b0;
                else if (i == 0) chain_q[i] <= async_in;
                else             chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            rise   <= 1'b0;
            fall   <= 1'b0;
        end else begin
            prev_q <= synced;
            rise   <= en && synced && !prev_q;
            fall   <= en && !synced && prev_q;
        end
    end

    // R6
    slave_rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_mode,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             cs_n,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             sclk_rise,
    output logic             sclk_fall
);
    sclk_state_e state_q, state_d;
    logic m_run, s_run, tick;
    logic m_sclk, m_rise, m_fall, s_rise, s_fall;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!cs_n) state_d = slave_mode ? ST_SLAVE : ST_MASTER;
            ST_MASTER: if (cs_n) state_d = ST_IDLE;
                       else if (slave_mode) state_d = ST_SLAVE;
            ST_SLAVE:  if (cs_n) state_d = ST_IDLE;
                       else if (!slave_mode) state_d = ST_MASTER;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign m_run = (state_d == ST_MASTER);
    assign s_run = (state_d == ST_SLAVE);

    sck_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(m_run), .ratio(div_ratio), .tick(tick)
    );

    sck_half_stage u_half (
        .clk(clk), .rst_n(rst_n), .run(m_run), .idle_lvl(cpol), .tick(tick),
        .sclk(m_sclk), .rise(m_rise), .fall(m_fall)
    );

    sck_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .en(s_run), .async_in(sclk_in),
        .rise(s_rise), .fall(s_fall)
    );

    always_comb begin
        sclk_out  = m_sclk;
        sclk_oe   = !slave_mode;
        sclk_rise = m_rise | s_rise;
        sclk_fall = m_fall | s_fall;
    end

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sclk_rise && !sclk_fall && sclk_out == $past(cpol)));
    // R5
    master_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && sclk_oe && $past(sclk_oe)) |-> (sclk_out && !$past(sclk_out)));
    // R5
    master_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && sclk_oe && $past(sclk_oe)) |-> (!sclk_out && $past(sclk_out)));
endmodule

// File: tb/spi_sclk_gen_tb.sv
module spi_sclk_gen_tb;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_mode = 1'b0;
    logic cpol = 1'b0;
    logic [DIV_W-1:0] div_ratio = '0;
    logic cs_n = 1'b1;
    logic sclk_in = 1'b0;
    logic sclk_out, sclk_oe, sclk_rise, sclk_fall;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_sclk_gen #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .cpol(cpol),
        .div_ratio(div_ratio), .cs_n(cs_n), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_level(int e, int div, logic pol);
        int toggles = e / (div + 1);
        return pol ^ toggles[0];
    endfunction

    task automatic master_run(int div, logic pol, int n_edges);
        logic prev_lvl;
        bit seen_first = 1'b0;
        @(negedge clk);
        slave_mode = 1'b0; cpol = pol; div_ratio = DIV_W'(div); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 idle level", {31'd0, sclk_out}, {31'd0, pol});
        chk("R2 idle strobes", {30'd0, sclk_rise, sclk_fall}, 32'd0);
        chk("R7 master oe", {31'd0, sclk_oe}, 32'd1);
        prev_lvl = pol;
        cs_n = 1'b0;
        for (int e = 1; e <= n_edges; e++) begin
            logic lvl;
            logic tog;
            @(negedge clk);
            lvl = exp_level(e, div, pol);
            tog = (lvl != prev_lvl);
            chk("R3 sclk level", {31'd0, sclk_out}, {31'd0, lvl});
            chk("R5 rise strobe", {31'd0, sclk_rise}, {31'd0, tog && lvl});
            chk("R5 fall strobe", {31'd0, sclk_fall}, {31'd0, tog && !lvl});
            if (tog && !seen_first) begin
                seen_first = 1'b1;
                chk("R4 first edge", {30'd0, sclk_rise, sclk_fall},
                    pol ? 32'd1 : 32'd2);
            end
            prev_lvl = lvl;
        end
        cs_n = 1'b1;
        @(negedge clk);
        chk("R2 after deassert level", {31'd0, sclk_out}, {31'd0, pol});
        chk("R2 after deassert strobes", {30'd0, sclk_rise, sclk_fall}, 32'd0);
    endtask

    task automatic slave_edge(logic v, logic cs_low, int gap);
        logic was;
        was = sclk_in;
        sclk_in = v;
        for (int k = 1; k <= gap; k++) begin
            @(negedge clk);
            if (k == 3 && cs_low && v != was) begin
                chk("R8 slave strobe", {30'd0, sclk_rise, sclk_fall}, v ? 32'd2 : 32'd1);
            end else begin
                chk(cs_low ? "R8 slave quiet" : "R9 slave cs high",
                    {30'd0, sclk_rise, sclk_fall}, 32'd0);
            end
            chk("R9 slave level", {31'd0, sclk_out}, {31'd0, cpol});
            chk("R7 slave oe", {31'd0, sclk_oe}, 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240517));
        #1;
        chk("R1 reset sclk", {31'd0, sclk_out}, 32'd0);
        chk("R1 reset strobes", {30'd0, sclk_rise, sclk_fall}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R1 reset held", {30'd0, sclk_rise, sclk_fall}, 32'd0);
        rst_n = 1'b1;

        master_run(0, 1'b0, 8);
        master_run(0, 1'b1, 8);
        master_run(3, 1'b1, 20);
        // R10: reassertion restarts numbering
        master_run(3, 1'b1, 11);
        master_run(2, 1'b0, 13);
        for (int t = 0; t < 20; t++) begin
            master_run(int'($urandom_range(0, 6)), 1'($urandom_range(0, 1)),
                       int'($urandom_range(6, 40)));
        end

        @(negedge clk);
        slave_mode = 1'b1; cpol = 1'b1; sclk_in = 1'b0; cs_n = 1'b0;
        repeat (5) @(negedge clk);
        slave_edge(1'b1, 1'b1, 5);
        slave_edge(1'b0, 1'b1, 4);
        cs_n = 1'b1;
        slave_edge(1'b1, 1'b0, 5);
        slave_edge(1'b0, 1'b0, 5);
        cs_n = 1'b0;
        cpol = 1'b0;
        repeat (4) @(negedge clk);
        for (int t = 0; t < 30; t++) begin
            slave_edge(~sclk_in, 1'b1, int'($urandom_range(4, 9)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule